// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the single atomic reservation of one processor core so that load-linked / store-conditional pairs work without any locked bus cycle. A load-linked event arms a reservation and records its address. The reservation is lost when the core takes an exception or interrupt. It is also lost when another agent is seen writing to the same cache line. A later store-conditional succeeds only if the reservation is still live and targets the reserved line.

A store-conditional that may succeed first requests exclusive ownership of the line through a request/grant handshake. It writes to the data cache only once the grant arrives. If the reservation is lost while the request waits, the store-conditional is abandoned and reports failure. Each store-conditional produces a one-cycle result pulse with a success flag. The reservation is always consumed, whatever the outcome. Software retries on failure.

Top module: `resv_monitor`

## Requirements
- R1: A load-linked pulse arms the reservation and records its address. A later load-linked replaces the recorded address, so a snoop to the old line no longer affects it.
- R2: An exception pulse clears the reservation at the next clock edge. A store-conditional that follows then fails.
- R3: A store-conditional with no reservation, or to a line other than the reserved one, gives `scDone`=1 and `scOk`=0 in the cycle after the request. It raises no `upgReq` and no `wrEn`.
- R4: Addresses are compared per line. `LINE_BYTES` defaults to 32, so address bits [4:0] are ignored in every comparison.
- R5: A snoop write to the reserved line, at any offset within it, clears the reservation. A snoop to a different line leaves the reservation intact.
- R6: A store-conditional that holds a live, matching reservation raises `upgReq` from the next cycle on. It holds `upgReq` until the grant or an abort, and writes nothing before the grant. A grant while no request is pending has no effect.
- R7: `upgGrant` sampled at a clock edge while `upgReq` is high gives, in the following cycle, a one-cycle `wrEn` carrying the store-conditional's full address and data, together with `scDone`=1 and `scOk`=1 (1 = success, 0 = failure).
- R8: The reservation is cleared after every store-conditional, whatever its outcome, so a second store-conditional without a new load-linked fails.
- R9: A snoop hit or an exception while `upgReq` waits aborts the store-conditional. This still applies when the grant arrives in the same cycle. The abort gives `scDone`=1, `scOk`=0, no write, and `upgReq` dropped.
- R10: A snoop hit in the same cycle as a store-conditional request takes priority, and the store-conditional fails.
- R11: After reset no reservation is held and `upgReq`, `wrEn` and `scDone` are 0. `busLock` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| llValid | input | 1 | Load-linked event pulse |
| llAddr | input | ADDR_W | Load-linked byte address |
| scValid | input | 1 | Store-conditional request pulse |
| scAddr | input | ADDR_W | Store-conditional byte address |
| scData | input | DATA_W | Store-conditional data |
| excEntry | input | 1 | Exception or interrupt entry pulse |
| snoopValid | input | 1 | Foreign write observed on the bus |
| snoopAddr | input | ADDR_W | Address of the foreign write |
| upgReq | output | 1 | Request exclusive ownership of the line |
| upgGrant | input | 1 | Exclusive ownership granted |
| wrEn | output | 1 | Data cache write strobe |
| wrAddr | output | ADDR_W | Data cache write address |
| wrData | output | DATA_W | Data cache write data |
| scDone | output | 1 | Store-conditional result valid |
| scOk | output | 1 | 1 = store-conditional succeeded |
| busLock | output | 1 | Bus lock request, held at 0 |

## Verification
The store-conditional is driven after a clean load-linked, after no load-linked at all, after an exception, after snoops to the same line at another offset and to a neighbouring line, and to a line other than the reserved one. Comparing these outcomes separates line-granular matching from exact-address matching, and shows which events consume the reservation. The upgrade handshake is run with a grant delayed by several cycles, with a snoop or exception during the wait, and with an exception landing together with the grant. This exposes a design that writes before ownership or lets a late grant override an abort. Repeating a store-conditional, re-arming onto a new line, and a spurious grant while idle show that the reservation is consumed each time and that an idle grant does nothing.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } resvState_t;

  typedef struct packed {
    logic setResv;
    logic clearResv;
    logic captureSc;
    logic issueWrite;
    logic reportDone;
    logic reportOk;
  } ctlStrobes_t;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [DATA_W-1:0] scData,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              resvValid,
  output logic [ADDR_W-1:0] resvAddr,
  output logic              snoopHit,
  output logic              scLineHit,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              scDone,
  output logic              scOk
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << OFF_W;

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;

  function automatic logic sameLine(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] b);
    return ((a ^ b) & LINE_MASK) == '0;
  endfunction

  assign snoopHit  = snoopValid && resvValid && sameLine(snoopAddr, resvAddr);
  assign scLineHit = sameLine(scAddr, resvAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvAddr  <= '0;
    end else if (strb.clearResv) begin
      resvValid <= 1'b0;
    end else if (strb.setResv) begin
      resvValid <= 1'b1;
      resvAddr  <= llAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
    end else if (strb.captureSc) begin
      pendAddr <= scAddr;
      pendData <= scData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
      scDone <= 1'b0;
      scOk   <= 1'b0;
    end else begin
      wrEn   <= strb.issueWrite;
      scDone <= strb.reportDone;
      scOk   <= strb.reportOk;
      if (strb.issueWrite) begin
        wrAddr <= pendAddr;
        wrData <= pendData;
      end
    end
  end

endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        llValid,
  input  logic        scValid,
  input  logic        excEntry,
  input  logic        upgGrant,
  input  logic        resvValid,
  input  logic        snoopHit,
  input  logic        scLineHit,
  output logic        upgReq,
  output ctlStrobes_t strb
);

  resvState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign upgReq = (state == ST_WAIT);

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (scValid) begin
          strb.captureSc = 1'b1;
          if (resvValid && scLineHit && !snoopHit && !excEntry) begin
            stateNext = ST_WAIT;
          end else begin
            strb.reportDone = 1'b1;
            strb.clearResv  = 1'b1;
          end
        end else if (excEntry) begin
          strb.clearResv = 1'b1;
        end else if (llValid) begin
          strb.setResv = 1'b1;
        end else if (snoopHit) begin
          strb.clearResv = 1'b1;
        end
      end
      ST_WAIT: begin
        if (excEntry || snoopHit) begin
          strb.reportDone = 1'b1;
          strb.clearResv  = 1'b1;
          stateNext       = ST_IDLE;
        end else if (upgGrant) begin
          strb.issueWrite = 1'b1;
          strb.reportDone = 1'b1;
          strb.reportOk   = 1'b1;
          strb.clearResv  = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              llValid,
  input  logic [ADDR_W-1:0] llAddr,
  input  logic              scValid,
  input  logic [ADDR_W-1:0] scAddr,
  input  logic [DATA_W-1:0] scData,
  input  logic              excEntry,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              upgReq,
  input  logic              upgGrant,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              scDone,
  output logic              scOk,
  output logic              busLock
);

  ctlStrobes_t       strb;
  logic              resvValid;
  logic [ADDR_W-1:0] resvAddr;
  logic              snoopHit;
  logic              scLineHit;

  assign busLock = 1'b0;

  resv_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .llValid   (llValid),
    .scValid   (scValid),
    .excEntry  (excEntry),
    .upgGrant  (upgGrant),
    .resvValid (resvValid),
    .snoopHit  (snoopHit),
    .scLineHit (scLineHit),
    .upgReq    (upgReq),
    .strb      (strb)
  );

  resv_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .llAddr     (llAddr),
    .scAddr     (scAddr),
    .scData     (scData),
    .snoopValid (snoopValid),
    .snoopAddr  (snoopAddr),
    .resvValid  (resvValid),
    .resvAddr   (resvAddr),
    .snoopHit   (snoopHit),
    .scLineHit  (scLineHit),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .scDone     (scDone),
    .scOk       (scOk)
  );

endmodule

// File: rtl/resv_checker.sv
module resv_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              llValid,
  input logic              scValid,
  input logic              excEntry,
  input logic              snoopValid,
  input logic [ADDR_W-1:0] snoopAddr,
  input logic              upgReq,
  input logic              upgGrant,
  input logic              wrEn,
  input logic              scDone,
  input logic              scOk,
  input logic              resvValid,
  input logic [ADDR_W-1:0] resvAddr
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << OFF_W;

  logic snoopSameLine;
  assign snoopSameLine = snoopValid && (((snoopAddr ^ resvAddr) & LINE_MASK) == '0);

  AST_EXC_DROPS_RESV: assert property (@(posedge clk) disable iff (!rstN)
    excEntry |=> !resvValid) else $error("exception kept reservation"); // R2

  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (scDone && !scOk) |-> !wrEn) else $error("write on failed sc"); // R3

  AST_SNOOP_DROPS_RESV: assert property (@(posedge clk) disable iff (!rstN)
    (resvValid && snoopSameLine && !llValid && !scValid) |=> !resvValid)
    else $error("snoop hit kept reservation"); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (upgReq && !upgGrant && !excEntry && !snoopValid) |=> upgReq)
    else $error("upgrade request dropped early"); // R6

  AST_WRITE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(upgReq && upgGrant)) else $error("write without grant"); // R7

  AST_WRITE_IS_SUCCESS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (scDone && scOk)) else $error("write without success"); // R7

  AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (!rstN)
    scDone |-> !resvValid) else $error("reservation survived sc"); // R8

  AST_EXC_ABORTS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (upgReq && excEntry) |=> (scDone && !scOk && !wrEn))
    else $error("exception did not abort"); // R9

  AST_SC_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !upgReq && !resvValid) |=> (scDone && !scOk))
    else $error("sc without reservation not failed"); // R3

endmodule

bind resv_monitor resv_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .llValid    (llValid),
  .scValid    (scValid),
  .excEntry   (excEntry),
  .snoopValid (snoopValid),
  .snoopAddr  (snoopAddr),
  .upgReq     (upgReq),
  .upgGrant   (upgGrant),
  .wrEn       (wrEn),
  .scDone     (scDone),
  .scOk       (scOk),
  .resvValid  (resvValid),
  .resvAddr   (resvAddr)
);

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          llValid = 1'b0;
  logic [AW-1:0] llAddr = '0;
  logic          scValid = 1'b0;
  logic [AW-1:0] scAddr = '0;
  logic [DW-1:0] scData = '0;
  logic          excEntry = 1'b0;
  logic          snoopValid = 1'b0;
  logic [AW-1:0] snoopAddr = '0;
  logic          upgGrant = 1'b0;
  logic          upgReq, wrEn, scDone, scOk, busLock;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(32)) i_resv_monitor (
    .clk(clk), .rstN(rstN), .llValid(llValid), .llAddr(llAddr),
    .scValid(scValid), .scAddr(scAddr), .scData(scData),
    .excEntry(excEntry), .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .upgReq(upgReq), .upgGrant(upgGrant), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .scDone(scDone), .scOk(scOk), .busLock(busLock)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R11", "busLock", {31'b0, busLock}, 32'h0);
  endtask

  task automatic doLl(input logic [AW-1:0] a);
    llValid = 1'b1; llAddr = a;
    tick();
    llValid = 1'b0;
  endtask

  task automatic doSnoop(input logic [AW-1:0] a);
    snoopValid = 1'b1; snoopAddr = a;
    tick();
    snoopValid = 1'b0;
  endtask

  task automatic doSc(input logic [AW-1:0] a, input logic [DW-1:0] d);
    scValid = 1'b1; scAddr = a; scData = d;
    tick();
    scValid = 1'b0;
  endtask

  task automatic expectFail(input string req);
    chk(req, "scDone", {31'b0, scDone}, 32'h1);
    chk(req, "scOk",   {31'b0, scOk},   32'h0);
    chk(req, "wrEn",   {31'b0, wrEn},   32'h0);
    chk(req, "upgReq", {31'b0, upgReq}, 32'h0);
  endtask

  task automatic grantAndExpectWrite(input string req, input logic [AW-1:0] a,
                                     input logic [DW-1:0] d);
    upgGrant = 1'b1;
    tick();
    upgGrant = 1'b0;
    chk(req, "wrEn",   {31'b0, wrEn},   32'h1);
    chk(req, "wrAddr", wrAddr, a);
    chk(req, "wrData", wrData, d);
    chk(req, "scDone", {31'b0, scDone}, 32'h1);
    chk(req, "scOk",   {31'b0, scOk},   32'h1);
    chk(req, "upgReq", {31'b0, upgReq}, 32'h0);
    tick();
    chk(req, "wrEn pulse", {31'b0, wrEn}, 32'h0);
  endtask

  // R11 reset state, R3 sc with no reservation
  task automatic testReset();
    chk("R11", "upgReq", {31'b0, upgReq}, 32'h0);
    chk("R11", "wrEn",   {31'b0, wrEn},   32'h0);
    chk("R11", "scDone", {31'b0, scDone}, 32'h0);
    doSc(32'h0000_0040, 32'h1111_1111);
    expectFail("R3");
    tick();
  endtask

  // R6 delayed grant, R7 write, R4 offset ignored, R8 consumed
  task automatic testSuccess();
    doLl(32'h0000_0100);
    doSc(32'h0000_0104, 32'hCAFE_0001);
    chk("R6", "upgReq", {31'b0, upgReq}, 32'h1);
    chk("R6", "scDone", {31'b0, scDone}, 32'h0);
    tick(); tick();
    chk("R6", "upgReq held", {31'b0, upgReq}, 32'h1);
    chk("R6", "no early write", {31'b0, wrEn}, 32'h0);
    grantAndExpectWrite("R7", 32'h0000_0104, 32'hCAFE_0001);
    doSc(32'h0000_0104, 32'hCAFE_0002);
    expectFail("R8");
    tick();
  endtask

  // R2 exception clears
  task automatic testException();
    doLl(32'h0000_0300);
    excEntry = 1'b1; tick(); excEntry = 1'b0;
    doSc(32'h0000_0300, 32'h0);
    expectFail("R2");
    tick();
  endtask

  // R5 / R4 snoop same line other offset vs neighbouring line
  task automatic testSnoop();
    doLl(32'h0000_0200);
    doSnoop(32'h0000_021C);
    doSc(32'h0000_0200, 32'h5);
    expectFail("R5");
    tick();
    doLl(32'h0000_0200);
    doSnoop(32'h0000_0220);
    doSc(32'h0000_0200, 32'hBEEF_0005);
    chk("R5", "neighbour snoop keeps resv", {31'b0, upgReq}, 32'h1);
    grantAndExpectWrite("R5", 32'h0000_0200, 32'hBEEF_0005);
  endtask

  // R9 aborts during wait
  task automatic testAbort();
    doLl(32'h0000_0500);
    doSc(32'h0000_0500, 32'h9);
    tick();
    doSnoop(32'h0000_051F);
    expectFail("R9");
    tick();
    doLl(32'h0000_0540);
    doSc(32'h0000_0540, 32'hA);
    excEntry = 1'b1; upgGrant = 1'b1;
    tick();
    excEntry = 1'b0; upgGrant = 1'b0;
    expectFail("R9");
    tick();
  endtask

  // R10 snoop and sc together
  task automatic testSameCycle();
    doLl(32'h0000_0600);
    scValid = 1'b1; scAddr = 32'h0000_0600; scData = 32'h6;
    snoopValid = 1'b1; snoopAddr = 32'h0000_0608;
    tick();
    scValid = 1'b0; snoopValid = 1'b0;
    expectFail("R10");
    tick();
  endtask

  // R3 wrong line, R6 idle grant ignored
  task automatic testWrongLine();
    doLl(32'h0000_0700);
    doSc(32'h0000_0720, 32'h7);
    expectFail("R3");
    upgGrant = 1'b1; tick(); upgGrant = 1'b0;
    tick();
    chk("R6", "idle grant no write", {31'b0, wrEn}, 32'h0);
    chk("R6", "idle grant no done", {31'b0, scDone}, 32'h0);
  endtask

  // R1 re-arm moves reservation
  task automatic testRearm();
    doLl(32'h0000_0800);
    doLl(32'h0000_0900);
    doSnoop(32'h0000_0800);
    doSc(32'h0000_0910, 32'h1234_5678);
    chk("R1", "new line armed", {31'b0, upgReq}, 32'h1);
    grantAndExpectWrite("R1", 32'h0000_0910, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testSuccess();
    testException();
    testSnoop();
    testAbort();
    testSameCycle();
    testWrongLine();
    testRearm();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule